// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It walks a page directory and a page table that both sit in ordinary memory, and it uses a single 32-bit memory port to do so. A requester offers a linear address together with two flags: whether the access is a write and whether it comes from user privilege. The walker reads the directory entry. If the entry's accessed flag is clear, it writes the entry back with that flag set. It then either forms a 4 MiB large-page address or reads and updates a table entry. Last, it decides whether the access is allowed. Three configuration inputs choose its behaviour: the page frame of the directory, whether supervisor writes honour read-only pages, and whether large pages are recognised. All three are captured when a request is accepted.

The walker is a single state machine. Its states are:

- `ST_IDLE`: waits for a request.
- `ST_DIR_RD`: reads the directory entry.
- `ST_DIR_WB`: writes back the directory entry with the accessed flag set.
- `ST_TBL_RD`: reads the table entry.
- `ST_TBL_WB`: writes back the table entry with the accessed flag set.
- `ST_CHECK`: evaluates permission.
- `ST_DONE`: presents the one-cycle response.

Its transitions are:

- Accept: `ST_IDLE` to `ST_DIR_RD`.
- Directory missing: `ST_DIR_RD` to `ST_DONE`.
- Directory mark: `ST_DIR_RD` to `ST_DIR_WB`.
- Directory descend: `ST_DIR_RD` or `ST_DIR_WB` to `ST_TBL_RD`.
- Large hit: `ST_DIR_RD` or `ST_DIR_WB` to `ST_CHECK`.
- Table missing: `ST_TBL_RD` to `ST_DONE`.
- Table mark: `ST_TBL_RD` to `ST_TBL_WB`.
- Table hit: `ST_TBL_RD` or `ST_TBL_WB` to `ST_CHECK`.
- Decide: `ST_CHECK` to `ST_DONE`.
- Release: `ST_DONE` to `ST_IDLE`.

Each memory state waits for `mem_ack`.

Top module: `pt_walker`

## Requirements
- R1: The first memory access of every walk is a read at address `{cfg_dir_frame, req_laddr[31:22], 2'b00}`.
- R2: If the directory entry has bit 0 (present) clear, the walk ends with a fault and makes no further memory access.
- R3: If a present directory entry has bit 5 (accessed) clear, the next access writes that entry, with bit 5 set, to the address it was read from. If bit 5 is already set, no write takes place.
- R4: When `cfg_large_en` is 1 and the directory entry has bit 7 set, no table is read and the physical address is `{pde[31:22], laddr[21:0]}`. When `cfg_large_en` is 0, bit 7 has no effect and the table is walked.
- R5: The table entry is read at `{pde[31:12], laddr[21:12], 2'b00}`.
- R6: A table entry with bit 0 clear ends the walk with a fault. A table entry with bit 0 set and bit 5 clear is written back to its own address with bit 5 set.
- R7: For a 4 KiB page, the physical address is `{pte[31:12], laddr[11:0]}`.
- R8: Permission is bit `{cfg_wp, user, ent_user, ent_writable, write}` (MSB first) of the constant 0xD0DDD0FF. Entry bit 2 means user and bit 1 means writable. For a 4 KiB page the entry bits are the AND of the directory and table bits; for a large page they are the directory bits. If the bit is 0, the walk faults.
- R9: With `cfg_wp`=1, a supervisor write to a page that is writable and user is allowed, and a supervisor write to a read-only page faults. With `cfg_wp`=0, every supervisor access is allowed.
- R10: On a fault, `rsp_paddr` is 0 and `rsp_code` holds {user, write, present}, where present is 0 for a missing entry and 1 for a permission denial. On success, `rsp_code` is 0.
- R11: `req_ready` is 1 only while idle. `rsp_valid` is a single-cycle pulse. Once raised, `mem_req` keeps its address and write flag until `mem_ack`.
- R12: After reset, `req_ready`=1, `mem_req`=0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Walker idle, request accepted on this cycle |
| req_laddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is at user privilege |
| cfg_dir_frame | input | 20 | Page frame number of the page directory |
| cfg_wp | input | 1 | Supervisor writes honour read-only pages |
| cfg_large_en | input | 1 | Recognise 4 MiB directory entries |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Pending access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Memory completes the pending access |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_code | output | 3 | Fault code {user, write, present} |

## Verification
The assertions assume three things about the inputs. Memory returns `mem_ack` only while `mem_req` is high. A request is offered only while `req_ready` is high, held for a single cycle. The configuration does not matter between acceptance and response, because it is captured. The stimulus keeps to these rules: the memory model acknowledges a pending access after zero to two wait cycles and then drops `mem_ack` for a cycle. A new request is started only after the previous response. Table entries are always placed away from the directory, so a table write can never alter a directory entry that the reference model has already predicted.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    localparam int unsigned ENTRY_W  = 32;
    localparam int unsigned OFS_W    = 12;
    localparam int unsigned IDX_W    = 10;
    localparam int unsigned SEL_W    = 2;
    localparam int unsigned FRAME_W  = ENTRY_W - OFS_W;
    localparam int unsigned LOFS_W   = IDX_W + OFS_W;
    localparam int unsigned CODE_W   = 3;
    localparam int unsigned PIDX_W   = 5;
    localparam int unsigned PMAP_W   = 1 << PIDX_W;

    localparam int unsigned BIT_PRESENT  = 0;
    localparam int unsigned BIT_WRITABLE = 1;
    localparam int unsigned BIT_USER     = 2;
    localparam int unsigned BIT_ACCESSED = 5;
    localparam int unsigned BIT_LARGE    = 7;

    localparam logic [ENTRY_W-1:0] ACC_MASK = ENTRY_W'(1) << BIT_ACCESSED;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_DIR_WB,
        ST_TBL_RD,
        ST_TBL_WB,
        ST_CHECK,
        ST_DONE
    } walk_state_e;

    function automatic logic is_large(input logic large_en, input logic [ENTRY_W-1:0] ent);
        return large_en & ent[BIT_LARGE];
    endfunction

endpackage

// File: rtl/pt_walk_addr.sv
module pt_walk_addr
    import pt_walker_pkg::*;
(
    input  logic [FRAME_W-1:0] dir_frame,
    input  logic [ENTRY_W-1:0] laddr,
    input  logic [FRAME_W-1:0] pde_frame,
    input  logic [FRAME_W-1:0] pte_frame,
    output logic [ENTRY_W-1:0] dir_addr,
    output logic [ENTRY_W-1:0] tbl_addr,
    output logic [ENTRY_W-1:0] pa_large,
    output logic [ENTRY_W-1:0] pa_small
);
    localparam int unsigned LBASE_W = ENTRY_W - LOFS_W;

    // directory slot from the top index field, table slot from the middle one
    assign dir_addr = {dir_frame, laddr[ENTRY_W-1 -: IDX_W], {SEL_W{1'b0}}};
    assign tbl_addr = {pde_frame, laddr[LOFS_W-1 -: IDX_W], {SEL_W{1'b0}}};
    assign pa_large = {pde_frame[FRAME_W-1 -: LBASE_W], laddr[LOFS_W-1:0]};
    assign pa_small = {pte_frame, laddr[OFS_W-1:0]};

endmodule

// File: rtl/pt_walk_perm.sv
module pt_walk_perm
    import pt_walker_pkg::*;
#(
    parameter logic [PMAP_W-1:0] GRANT_MAP = 32'hD0DD_D0FF
) (
    input  logic wp,
    input  logic cpl_user,
    input  logic ent_user,
    input  logic ent_wr,
    input  logic op_wr,
    output logic allow
);
    logic [PIDX_W-1:0] sel;

    assign sel   = {wp, cpl_user, ent_user, ent_wr, op_wr};
    assign allow = GRANT_MAP[sel];

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter logic [PMAP_W-1:0] GRANT_MAP = 32'hD0DD_D0FF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ENTRY_W-1:0] req_laddr,
    input  logic               req_write,
    input  logic               req_user,
    input  logic [FRAME_W-1:0] cfg_dir_frame,
    input  logic               cfg_wp,
    input  logic               cfg_large_en,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ENTRY_W-1:0] mem_addr,
    output logic [ENTRY_W-1:0] mem_wdata,
    input  logic               mem_ack,
    input  logic [ENTRY_W-1:0] mem_rdata,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [ENTRY_W-1:0] rsp_paddr,
    output logic [CODE_W-1:0]  rsp_code
);

    walk_state_e state_q, state_d;

    logic [ENTRY_W-1:0] laddr_q;
    logic               wr_q, usr_q, wp_q, lg_en_q;
    logic [FRAME_W-1:0] frame_q;
    logic [ENTRY_W-1:0] pde_q, pte_q;
    logic               flt_q;
    logic [ENTRY_W-1:0] pa_q;
    logic [CODE_W-1:0]  code_q;

    logic [ENTRY_W-1:0] dir_addr, tbl_addr, pa_large, pa_small;
    logic               large_hit, ent_user, ent_wr, allow;
    logic               accept;

    assign accept = req_valid && (state_q == ST_IDLE);

    pt_walk_addr u_addr (
        .dir_frame (frame_q),
        .laddr     (laddr_q),
        .pde_frame (pde_q[ENTRY_W-1:OFS_W]),
        .pte_frame (pte_q[ENTRY_W-1:OFS_W]),
        .dir_addr  (dir_addr),
        .tbl_addr  (tbl_addr),
        .pa_large  (pa_large),
        .pa_small  (pa_small)
    );

    assign large_hit = is_large(lg_en_q, pde_q);
    assign ent_user  = large_hit ? pde_q[BIT_USER]
                                 : (pde_q[BIT_USER] & pte_q[BIT_USER]);
    assign ent_wr    = large_hit ? pde_q[BIT_WRITABLE]
                                 : (pde_q[BIT_WRITABLE] & pte_q[BIT_WRITABLE]);

    pt_walk_perm #(.GRANT_MAP(GRANT_MAP)) u_perm (
        .wp       (wp_q),
        .cpl_user (usr_q),
        .ent_user (ent_user),
        .ent_wr   (ent_wr),
        .op_wr    (wr_q),
        .allow    (allow)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_DIR_RD;
            ST_DIR_RD: if (mem_ack) begin
                if (!mem_rdata[BIT_PRESENT])        state_d = ST_DONE;
                else if (!mem_rdata[BIT_ACCESSED])  state_d = ST_DIR_WB;
                else if (is_large(lg_en_q, mem_rdata)) state_d = ST_CHECK;
                else                                state_d = ST_TBL_RD;
            end
            ST_DIR_WB: if (mem_ack) state_d = large_hit ? ST_CHECK : ST_TBL_RD;
            ST_TBL_RD: if (mem_ack) begin
                if (!mem_rdata[BIT_PRESENT])        state_d = ST_DONE;
                else if (!mem_rdata[BIT_ACCESSED])  state_d = ST_TBL_WB;
                else                                state_d = ST_CHECK;
            end
            ST_TBL_WB: if (mem_ack) state_d = ST_CHECK;
            ST_CHECK:  state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_DIR_RD: begin
                mem_req  = 1'b1;
                mem_addr = dir_addr;
            end
            ST_DIR_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dir_addr;
                mem_wdata = pde_q | ACC_MASK;
            end
            ST_TBL_RD: begin
                mem_req  = 1'b1;
                mem_addr = tbl_addr;
            end
            ST_TBL_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tbl_addr;
                mem_wdata = pte_q | ACC_MASK;
            end
            ST_CHECK:  ;
            ST_DONE:   rsp_valid = 1'b1;
            default:   ;
        endcase
    end

    assign rsp_fault = flt_q;
    assign rsp_paddr = pa_q;
    assign rsp_code  = code_q;

    // walk context and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            laddr_q <= '0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            wp_q    <= 1'b0;
            lg_en_q <= 1'b0;
            frame_q <= '0;
            pde_q   <= '0;
            pte_q   <= '0;
            flt_q   <= 1'b0;
            pa_q    <= '0;
            code_q  <= '0;
        end else begin
            if (accept) begin
                laddr_q <= req_laddr;
                wr_q    <= req_write;
                usr_q   <= req_user;
                wp_q    <= cfg_wp;
                lg_en_q <= cfg_large_en;
                frame_q <= cfg_dir_frame;
                pte_q   <= '0;
            end
            if (mem_ack && (state_q == ST_DIR_RD || state_q == ST_TBL_RD)) begin
                if (state_q == ST_DIR_RD) pde_q <= mem_rdata;
                else                      pte_q <= mem_rdata;
                if (!mem_rdata[BIT_PRESENT]) begin
                    flt_q  <= 1'b1;
                    pa_q   <= '0;
                    code_q <= {usr_q, wr_q, 1'b0};
                end
            end
            if (state_q == ST_CHECK) begin
                if (allow) begin
                    flt_q  <= 1'b0;
                    pa_q   <= large_hit ? pa_large : pa_small;
                    code_q <= '0;
                end else begin
                    flt_q  <= 1'b1;
                    pa_q   <= '0;
                    code_q <= {usr_q, wr_q, 1'b1};
                end
            end
        end
    end

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
    import pt_walker_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [ENTRY_W-1:0] req_laddr,
    input logic [FRAME_W-1:0] cfg_dir_frame,
    input logic               mem_req,
    input logic               mem_we,
    input logic [ENTRY_W-1:0] mem_addr,
    input logic [ENTRY_W-1:0] mem_wdata,
    input logic               mem_ack,
    input logic [ENTRY_W-1:0] mem_rdata,
    input logic               rsp_valid,
    input logic               rsp_fault,
    input logic [ENTRY_W-1:0] rsp_paddr,
    input logic [CODE_W-1:0]  rsp_code
);
    logic [ENTRY_W-1:0] first_addr;
    logic               first_pend;
    logic [ENTRY_W-1:0] last_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_addr <= '0;
            first_pend <= 1'b0;
            last_rd    <= '0;
        end else begin
            if (req_valid && req_ready) begin
                first_addr <= {cfg_dir_frame, req_laddr[ENTRY_W-1 -: IDX_W], {SEL_W{1'b0}}};
                first_pend <= 1'b1;
            end else if (mem_req && mem_ack) begin
                first_pend <= 1'b0;
            end
            if (mem_req && mem_ack && !mem_we) last_rd <= mem_addr;
        end
    end

    AST_FIRST_READ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && first_pend) |-> (!mem_we && mem_addr == first_addr)); // R1

    AST_MISSING_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_we && !mem_rdata[BIT_PRESENT]) |=> !mem_req); // R2

    AST_WB_SAME_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr == last_rd && mem_wdata[BIT_ACCESSED])); // R3

    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R10

    AST_OK_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_code == '0)); // R10

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R11

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !rsp_valid)); // R11

endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_laddr     (req_laddr),
    .cfg_dir_frame (cfg_dir_frame),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_paddr     (rsp_paddr),
    .rsp_code      (rsp_code)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_laddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [19:0] cfg_dir_frame = 20'h00010;
    logic        cfg_wp = 1'b0;
    logic        cfg_large_en = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_code;

    always #5 clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
        .req_write(req_write), .req_user(req_user),
        .cfg_dir_frame(cfg_dir_frame), .cfg_wp(cfg_wp), .cfg_large_en(cfg_large_en),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_code(rsp_code)
    );

    typedef struct {
        bit          we;
        logic [31:0] addr;
        logic [31:0] data;
        string       tag;
    } mem_op_t;

    logic [31:0] mem [logic [31:0]];
    mem_op_t     exp_q[$];
    int          vectors = 0;
    int          miscompares = 0;
    int          cycles = 0;
    int          wait_cnt = 0;
    bit          finished = 0;

    bit          exp_flt;
    logic [31:0] exp_pa;
    logic [2:0]  exp_code;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            summary();
        end
    end

    // memory responder and per-access comparison against the predicted sequence
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            wait_cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
            wait_cnt = $urandom_range(0, 2);
        end else if (mem_req) begin
            if (wait_cnt > 0) wait_cnt--;
            else begin
                if (exp_q.size() == 0) begin
                    check(0, "R2 R11 unexpected access", mem_addr, 32'hx);
                end else begin
                    mem_op_t e;
                    e = exp_q.pop_front();
                    check(mem_we == e.we, {e.tag, " access kind"}, 32'(mem_we), 32'(e.we));
                    check(mem_addr == e.addr, {e.tag, " access address"}, mem_addr, e.addr);
                    if (e.we) check(mem_wdata == e.data, {e.tag, " write data"}, mem_wdata, e.data);
                end
                if (mem_we) mem[mem_addr] = mem_wdata;
                else        mem_rdata = rd(mem_addr);
                mem_ack = 1'b1;
            end
        end
    end

    // behavioural reference: predicts access list and response from memory contents
    task automatic model(input logic [31:0] la, input bit w, input bit u);
        logic [31:0] da, ta, pde, pte;
        bit eu, ew, ok;
        exp_q.delete();
        da  = {cfg_dir_frame, la[31:22], 2'b00};
        pde = rd(da);
        exp_q.push_back('{0, da, 32'h0, "R1"});
        if (!pde[0]) begin
            exp_flt = 1; exp_pa = 0; exp_code = {u, w, 1'b0};
            return;
        end
        if (!pde[5]) exp_q.push_back('{1, da, pde | 32'h20, "R3"});
        if (cfg_large_en && pde[7]) begin
            eu = pde[2]; ew = pde[1];
            exp_pa = {pde[31:22], la[21:0]};
        end else begin
            ta  = {pde[31:12], la[21:12], 2'b00};
            pte = rd(ta);
            exp_q.push_back('{0, ta, 32'h0, "R5"});
            if (!pte[0]) begin
                exp_flt = 1; exp_pa = 0; exp_code = {u, w, 1'b0};
                return;
            end
            if (!pte[5]) exp_q.push_back('{1, ta, pte | 32'h20, "R6"});
            eu = pde[2] & pte[2];
            ew = pde[1] & pte[1];
            exp_pa = {pte[31:12], la[11:0]};
        end
        if (u) ok = eu && (!w || ew);
        else   ok = !(cfg_wp && w && !ew);
        if (ok) begin
            exp_flt = 0; exp_code = 3'b000;
        end else begin
            exp_flt = 1; exp_pa = 0; exp_code = {u, w, 1'b1};
        end
    endtask

    task automatic walk(input logic [31:0] la, input bit w, input bit u, input string req);
        int n;
        model(la, w, u);
        @(negedge clk);
        check(req_ready == 1'b1, "R11 ready when idle", 32'(req_ready), 32'h1);
        req_laddr = la; req_write = w; req_user = u; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R11 busy after accept", 32'(req_ready), 32'h0);
        n = 0;
        while (!rsp_valid && n < 60) begin
            @(negedge clk);
            n++;
        end
        check(rsp_valid == 1'b1, {req, " response seen"}, 32'(rsp_valid), 32'h1);
        check(rsp_fault == exp_flt, {req, " fault"}, 32'(rsp_fault), 32'(exp_flt));
        check(rsp_paddr == exp_pa, {req, " R10 paddr"}, rsp_paddr, exp_pa);
        check(rsp_code == exp_code, {req, " R10 code"}, 32'(rsp_code), 32'(exp_code));
        check(exp_q.size() == 0, {req, " R2 accesses complete"}, 32'(exp_q.size()), 32'h0);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R11 response single pulse", 32'(rsp_valid), 32'h0);
    endtask

    function automatic logic [31:0] la_of(input int d, input int t, input int o);
        return {d[9:0], t[9:0], o[11:0]};
    endfunction

    function automatic logic [31:0] slot(input int d);
        return {cfg_dir_frame, d[9:0], 2'b00};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R12 reset ready", 32'(req_ready), 32'h1);
        check(mem_req == 1'b0, "R12 reset mem_req", 32'(mem_req), 32'h0);
        check(rsp_valid == 1'b0, "R12 reset rsp_valid", 32'(rsp_valid), 32'h0);
        rst_n = 1'b1;

        // R2: directory entry missing, for read and for user write
        walk(la_of(1, 4, 12'h010), 0, 0, "R2");
        walk(la_of(1, 4, 12'h010), 1, 1, "R2");

        // R3 R6 R7: both entries lack accessed flag, then repeat with flags set
        mem[slot(2)] = 32'h0002_0000 | 32'h7;
        mem[32'h0002_0000 + 3*4] = 32'h1234_5000 | 32'h7;
        walk(la_of(2, 3, 12'hABC), 1, 1, "R3 R6 R7");
        walk(la_of(2, 3, 12'h123), 0, 1, "R3 R7 no rewrite");

        // R4: large page on, then bit 7 ignored with large pages off
        mem[slot(3)] = 32'h0C00_0000 | 32'hA7;
        cfg_large_en = 1;
        walk(la_of(3, 9, 12'h456), 0, 1, "R4 large");
        mem[32'h0C00_0000 + 9*4] = 32'h0777_0000 | 32'h27;
        cfg_large_en = 0;
        walk(la_of(3, 9, 12'h456), 1, 0, "R4 R5 large ignored");

        // R6: table entry missing
        mem[slot(4)] = 32'h0003_0000 | 32'h27;
        walk(la_of(4, 5, 12'h0), 0, 0, "R6 missing");

        // R8 R9: full permission sweep over table entry user/writable bits
        mem[slot(5)] = 32'h0004_0000 | 32'h27;
        for (int k = 0; k < 4; k++)
            mem[32'h0004_0000 + k*4] = 32'h0100_0000 + (k << 12) | 32'h21 | (k[1] ? 32'h4 : 32'h0) | (k[0] ? 32'h2 : 32'h0);
        for (int wp = 0; wp < 2; wp++) begin
            cfg_wp = wp[0];
            for (int us = 0; us < 2; us++)
                for (int k = 0; k < 4; k++)
                    for (int wr = 0; wr < 2; wr++)
                        walk(la_of(5, k, 12'h3F0), wr[0], us[0],
                             (wp == 1 && us == 0 && wr == 1) ? "R9 R8" : "R8");
        end

        // R8: directory bits are ANDed in for small pages
        mem[slot(6)] = 32'h0006_0000 | 32'h23;
        mem[32'h0006_0000] = 32'h0222_0000 | 32'h27;
        walk(la_of(6, 0, 12'h8), 0, 1, "R8 combined user");
        walk(la_of(6, 0, 12'h8), 1, 0, "R8 combined super");

        // mixed walks across random entries and configurations
        for (int i = 0; i < 80; i++) begin
            int d;
            logic [31:0] pde;
            logic [31:0] tb;
            d = 8 + (i % 32);
            cfg_wp = $urandom_range(0, 1);
            cfg_large_en = $urandom_range(0, 1);
            if ($urandom_range(0, 1)) pde = (32'h0040_0000 * $urandom_range(1, 400)) | 32'h80;
            else pde = 32'h0050_0000 + (d << 12);
            pde = pde | ($urandom_range(0, 7) == 0 ? 32'h0 : 32'h1) | (32'($urandom_range(0, 1)) << 1)
                      | (32'($urandom_range(0, 1)) << 2) | (32'($urandom_range(0, 1)) << 5);
            mem[slot(d)] = pde;
            tb = {pde[31:12], 12'h0} + ((i % 16) * 4);
            mem[tb] = ({$urandom} & 32'hFFFF_F000) | ($urandom_range(0, 7) == 0 ? 32'h0 : 32'h1)
                      | (32'($urandom_range(0, 1)) << 1) | (32'($urandom_range(0, 1)) << 2)
                      | (32'($urandom_range(0, 1)) << 5);
            walk(la_of(d, i % 16, $urandom_range(0, 4095)), $urandom_range(0, 1), $urandom_range(0, 1),
                 "R4 R7 R8 mixed");
        end

        summary();
    end

endmodule